// File: doc/BRIEF.md
# MIDI channel message parser

This block turns a stream of MIDI-style bytes, one per accepted input beat, into decoded events. It recognises status bytes, tracks how many data bytes each kind of channel message needs, gathers those bytes (reusing the last status when data keeps arriving), and on the final byte of a message emits a one-cycle event strobe carrying a type code, a channel and the data fields. Note-off messages are folded into note events with zero velocity, pitch bend is delivered as an assembled 14-bit value with a marker bit, and system-exclusive traffic is passed through one byte per strobe with start and end flags.

The channel is formed from a small port index sampled with the status byte, placed above the low status nibble. Events whose channel is not below a limit (26 by default) are suppressed. Data bytes that arrive with no status in effect are dropped and counted in a saturating error counter. The input never stalls; the event output has no backpressure.

Top module: `midi_msg_parser`

## Requirements
- R1: Status high nibbles 0x8, 0x9, 0xA, 0xB and 0xE take two data bytes, 0xC and 0xD take one; the event strobe rises in the cycle after the edge that accepts the last data byte. Type codes: 1 note, 2 controller, 3 program, 4 pressure, 5 bend, 6 system-exclusive; nibble 0xA messages are collected but emit nothing. For one-data-byte messages the data byte is in `ev_d1` and `ev_d2` is 0; for controller messages `ev_d1` is the controller number and `ev_d2` its value.
- R2: `ev_chan` is `{port, status[3:0]}`, where the port is the value of `in_port` in the cycle the status byte was accepted.
- R3: A 0x9n message reports note number in `ev_d1` and velocity in `ev_d2`, so zero velocity appears as a note event with `ev_d2` = 0; a 0x8n message is reported as a note event with `ev_d2` forced to 0 whatever its second data byte.
- R4: A channel message whose channel is 26 or more produces no strobe, while its bytes are still consumed so later messages stay aligned.
- R5: A bend event carries the first data byte (LSB) in `ev_d1`, the second (MSB) in `ev_d2`, and `ev_bend` = 16'h8000 | (MSB << 7) | LSB; for every other type `ev_bend` is 0.
- R6: 0xF0 opens a system-exclusive frame and emits nothing; each data byte inside the frame emits a type-6 event with the byte in `ev_d1`, `ev_sx_start` set on the first one only; 0xF7 closes the frame with a type-6 event having `ev_sx_end` set, `ev_d1` 0, and `ev_sx_start` set if the frame held no data. Channel is 0 on these events.
- R7: A status byte other than 0xF7 arriving in the middle of a message or frame discards the partial message without an event and takes effect itself.
- R8: 0xF7 arriving outside a system-exclusive frame has no effect; a channel message in progress completes normally.
- R9: After a channel message completes, further data bytes are collected as a new message with the same status and channel.
- R10: A data byte with no status in effect (after reset, or after a status 0xF1..0xFF other than 0xF0 and 0xF7) is dropped and increments `err_count`, which saturates at all ones.
- R11: After reset `ev_valid` is 0, `err_count` is 0 and `in_ready` is 1 (input never stalls).
- R12: A cycle with `in_valid` low changes no parser state and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Always high: a byte is accepted every valid cycle |
| in_byte | input | 8 | Stream byte |
| in_port | input | PORT_W (1) | Port index, sampled with a status byte |
| ev_valid | output | 1 | One-cycle event strobe |
| ev_kind | output | 3 | Event type code |
| ev_chan | output | PORT_W+4 (5) | Event channel |
| ev_d1 | output | 7 | First data field |
| ev_d2 | output | 7 | Second data field |
| ev_bend | output | 16 | Assembled bend word with marker bit 15 |
| ev_sx_start | output | 1 | First event of a system-exclusive frame |
| ev_sx_end | output | 1 | Closing event of a system-exclusive frame |
| err_count | output | ERR_W (8) | Saturating count of orphan data bytes |

## Verification
The byte that completes a message under running status can also be the byte whose event is suppressed by the channel limit, so in one cycle the collector both resets its byte count for the next message and the event stage throws the result away. The bench provokes this by opening a controller status on port 1 with a high nibble giving channel 27 and streaming several data pairs, then a status on channel 25; it judges that no strobe appears during the rejected pairs and that the following in-range message is reported with the right pairing of data bytes. Random streams mixing out-of-range channels, frame bytes and stray status bytes repeat the coincidence against a bench model.

// File: rtl/midi_parser_pkg.sv
`timescale 1ns/1ps
package midi_parser_pkg;

    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_NOTE = 3'd1,
        EV_CTRL = 3'd2,
        EV_PROG = 3'd3,
        EV_PRES = 3'd4,
        EV_BEND = 3'd5,
        EV_SYSX = 3'd6
    } ev_kind_e;

    localparam logic [7:0] SX_OPEN  = 8'hF0;
    localparam logic [7:0] SX_CLOSE = 8'hF7;
    localparam logic [3:0] HI_SYS   = 4'hF;

    // number of data bytes a channel status needs
    function automatic logic [1:0] data_bytes(input logic [3:0] hi);
        case (hi)
            4'hC, 4'hD: data_bytes = 2'd1;
            default:    data_bytes = 2'd2;
        endcase
    endfunction

    function automatic ev_kind_e kind_of(input logic [3:0] hi);
        case (hi)
            4'h8, 4'h9: kind_of = EV_NOTE;
            4'hB:       kind_of = EV_CTRL;
            4'hC:       kind_of = EV_PROG;
            4'hD:       kind_of = EV_PRES;
            4'hE:       kind_of = EV_BEND;
            4'hF:       kind_of = EV_SYSX;
            default:    kind_of = EV_NONE;
        endcase
    endfunction

endpackage

// File: rtl/midi_byte_class.sv
`timescale 1ns/1ps
module midi_byte_class
    import midi_parser_pkg::*;
(
    input  logic [7:0] byte_i,
    output logic       is_data,
    output logic       is_sx_open,
    output logic       is_sx_close,
    output logic       is_chan_stat,
    output logic       is_sys_other
);
    always_comb begin
        is_data      = !byte_i[7];
        is_sx_open   = (byte_i == SX_OPEN);
        is_sx_close  = (byte_i == SX_CLOSE);
        is_chan_stat = byte_i[7] && (byte_i[7:4] != HI_SYS);
        is_sys_other = (byte_i[7:4] == HI_SYS) && !is_sx_open && !is_sx_close;
    end
endmodule

// File: rtl/midi_msg_collector.sv
`timescale 1ns/1ps
module midi_msg_collector
    import midi_parser_pkg::*;
#(
    parameter int PORT_W = 1,
    parameter int ERR_W  = 8,
    localparam int CH_W  = PORT_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic [PORT_W-1:0] in_port,
    input  logic              is_data,
    input  logic              is_sx_open,
    input  logic              is_sx_close,
    input  logic              is_chan_stat,
    input  logic              is_sys_other,
    output logic              cand_vld,
    output logic [3:0]        cand_hi,
    output logic [CH_W-1:0]   cand_chan,
    output logic [6:0]        cand_d1,
    output logic [6:0]        cand_d2,
    output logic              cand_sxs,
    output logic              cand_sxe,
    output logic [ERR_W-1:0]  err_count
);
    typedef struct packed {
        logic             run_vld;
        logic [3:0]       run_hi;
        logic [CH_W-1:0]  run_ch;
        logic             have_d0;
        logic [6:0]       d0;
        logic             in_sx;
        logic             sx_first;
        logic [ERR_W-1:0] err;
    } col_t;

    col_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        cand_vld  = 1'b0;
        cand_hi   = 4'h0;
        cand_chan = '0;
        cand_d1   = 7'h00;
        cand_d2   = 7'h00;
        cand_sxs  = 1'b0;
        cand_sxe  = 1'b0;
        if (in_valid) begin
            if (is_sx_open) begin
                st_d.in_sx    = 1'b1;
                st_d.sx_first = 1'b1;
                st_d.run_vld  = 1'b0;
                st_d.have_d0  = 1'b0;
            end else if (is_sx_close) begin
                if (st_q.in_sx) begin
                    cand_vld      = 1'b1;
                    cand_hi       = HI_SYS;
                    cand_sxs      = st_q.sx_first;
                    cand_sxe      = 1'b1;
                    st_d.in_sx    = 1'b0;
                    st_d.sx_first = 1'b0;
                end
            end else if (is_chan_stat) begin
                st_d.run_vld  = 1'b1;
                st_d.run_hi   = in_byte[7:4];
                st_d.run_ch   = {in_port, in_byte[3:0]};
                st_d.have_d0  = 1'b0;
                st_d.in_sx    = 1'b0;
                st_d.sx_first = 1'b0;
            end else if (is_sys_other) begin
                st_d.run_vld  = 1'b0;
                st_d.have_d0  = 1'b0;
                st_d.in_sx    = 1'b0;
                st_d.sx_first = 1'b0;
            end else if (is_data) begin
                if (st_q.in_sx) begin
                    cand_vld      = 1'b1;
                    cand_hi       = HI_SYS;
                    cand_d1       = in_byte[6:0];
                    cand_sxs      = st_q.sx_first;
                    st_d.sx_first = 1'b0;
                end else if (!st_q.run_vld) begin
                    if (st_q.err != '1) st_d.err = st_q.err + 1'b1;
                end else if (data_bytes(st_q.run_hi) == 2'd1) begin
                    cand_vld  = 1'b1;
                    cand_hi   = st_q.run_hi;
                    cand_chan = st_q.run_ch;
                    cand_d1   = in_byte[6:0];
                end else if (st_q.have_d0) begin
                    cand_vld     = 1'b1;
                    cand_hi      = st_q.run_hi;
                    cand_chan    = st_q.run_ch;
                    cand_d1      = st_q.d0;
                    cand_d2      = in_byte[6:0];
                    st_d.have_d0 = 1'b0;
                end else begin
                    st_d.d0      = in_byte[6:0];
                    st_d.have_d0 = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_count = st_q.err;

    assert_err_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err >= $past(st_q.err));

    assert_idle_holds_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q));

    assert_frame_excludes_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.in_sx && st_q.run_vld));

    assert_partial_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.have_d0 |-> st_q.run_vld);

endmodule

// File: rtl/midi_event_stage.sv
`timescale 1ns/1ps
module midi_event_stage
    import midi_parser_pkg::*;
#(
    parameter int CH_W       = 5,
    parameter int CHAN_LIMIT = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cand_vld,
    input  logic [3:0]      cand_hi,
    input  logic [CH_W-1:0] cand_chan,
    input  logic [6:0]      cand_d1,
    input  logic [6:0]      cand_d2,
    input  logic            cand_sxs,
    input  logic            cand_sxe,
    output logic            ev_valid,
    output logic [2:0]      ev_kind,
    output logic [CH_W-1:0] ev_chan,
    output logic [6:0]      ev_d1,
    output logic [6:0]      ev_d2,
    output logic [15:0]     ev_bend,
    output logic            ev_sx_start,
    output logic            ev_sx_end
);
    localparam logic [CH_W:0] LIM = CHAN_LIMIT[CH_W:0];

    typedef struct packed {
        logic            v;
        ev_kind_e        k;
        logic [CH_W-1:0] ch;
        logic [6:0]      d1;
        logic [6:0]      d2;
        logic [15:0]     bend;
        logic            sxs;
        logic            sxe;
    } out_t;

    out_t out_d, out_q;
    ev_kind_e kind;
    logic     in_range;

    always_comb begin
        kind     = kind_of(cand_hi);
        in_range = ({1'b0, cand_chan} < LIM);
        out_d    = '0;
        if (cand_vld && kind != EV_NONE && (kind == EV_SYSX || in_range)) begin
            out_d.v   = 1'b1;
            out_d.k   = kind;
            out_d.ch  = cand_chan;
            out_d.d1  = cand_d1;
            out_d.d2  = (cand_hi == 4'h8) ? 7'h00 : cand_d2;
            out_d.sxs = cand_sxs;
            out_d.sxe = cand_sxe;
            if (kind == EV_BEND) out_d.bend = {2'b10, cand_d2, cand_d1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ev_valid    = out_q.v;
    assign ev_kind     = out_q.k;
    assign ev_chan     = out_q.ch;
    assign ev_d1       = out_q.d1;
    assign ev_d2       = out_q.d2;
    assign ev_bend     = out_q.bend;
    assign ev_sx_start = out_q.sxs;
    assign ev_sx_end   = out_q.sxe;

    assert_chan_below_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind != EV_SYSX) |-> ({1'b0, ev_chan} < LIM));

    assert_event_has_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_kind != EV_NONE));

    assert_event_from_candidate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> $past(cand_vld));

endmodule

// File: rtl/midi_msg_parser.sv
`timescale 1ns/1ps
module midi_msg_parser
    import midi_parser_pkg::*;
#(
    parameter int PORT_W     = 1,
    parameter int ERR_W      = 8,
    parameter int CHAN_LIMIT = 26,
    localparam int CH_W      = PORT_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    input  logic [PORT_W-1:0] in_port,
    output logic              ev_valid,
    output logic [2:0]        ev_kind,
    output logic [CH_W-1:0]   ev_chan,
    output logic [6:0]        ev_d1,
    output logic [6:0]        ev_d2,
    output logic [15:0]       ev_bend,
    output logic              ev_sx_start,
    output logic              ev_sx_end,
    output logic [ERR_W-1:0]  err_count
);
    logic is_data, is_sx_open, is_sx_close, is_chan_stat, is_sys_other;
    logic            cand_vld, cand_sxs, cand_sxe;
    logic [3:0]      cand_hi;
    logic [CH_W-1:0] cand_chan;
    logic [6:0]      cand_d1, cand_d2;

    assign in_ready = 1'b1;

    midi_byte_class class_i (
        .byte_i       (in_byte),
        .is_data      (is_data),
        .is_sx_open   (is_sx_open),
        .is_sx_close  (is_sx_close),
        .is_chan_stat (is_chan_stat),
        .is_sys_other (is_sys_other)
    );

    midi_msg_collector #(.PORT_W(PORT_W), .ERR_W(ERR_W)) coll_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_port      (in_port),
        .is_data      (is_data),
        .is_sx_open   (is_sx_open),
        .is_sx_close  (is_sx_close),
        .is_chan_stat (is_chan_stat),
        .is_sys_other (is_sys_other),
        .cand_vld     (cand_vld),
        .cand_hi      (cand_hi),
        .cand_chan    (cand_chan),
        .cand_d1      (cand_d1),
        .cand_d2      (cand_d2),
        .cand_sxs     (cand_sxs),
        .cand_sxe     (cand_sxe),
        .err_count    (err_count)
    );

    midi_event_stage #(.CH_W(CH_W), .CHAN_LIMIT(CHAN_LIMIT)) evt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_vld    (cand_vld),
        .cand_hi     (cand_hi),
        .cand_chan   (cand_chan),
        .cand_d1     (cand_d1),
        .cand_d2     (cand_d2),
        .cand_sxs    (cand_sxs),
        .cand_sxe    (cand_sxe),
        .ev_valid    (ev_valid),
        .ev_kind     (ev_kind),
        .ev_chan     (ev_chan),
        .ev_d1       (ev_d1),
        .ev_d2       (ev_d2),
        .ev_bend     (ev_bend),
        .ev_sx_start (ev_sx_start),
        .ev_sx_end   (ev_sx_end)
    );

    assert_event_needs_input_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> $past(in_valid));

    assert_frame_flags_only_sysex_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sx_start || ev_sx_end) |-> (ev_valid && ev_kind == 3'd6));

endmodule

// File: tb/midi_msg_parser_tb.sv
`timescale 1ns/1ps
module midi_msg_parser_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [0:0] in_port = 1'b0;
    logic       in_ready, ev_valid, ev_sx_start, ev_sx_end;
    logic [2:0] ev_kind;
    logic [4:0] ev_chan;
    logic [6:0] ev_d1, ev_d2;
    logic [15:0] ev_bend;
    logic [7:0] err_count;

    always #5 clk = ~clk;

    midi_msg_parser dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_port(in_port), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_chan(ev_chan), .ev_d1(ev_d1), .ev_d2(ev_d2), .ev_bend(ev_bend),
        .ev_sx_start(ev_sx_start), .ev_sx_end(ev_sx_end), .err_count(err_count)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // bench model state
    bit       m_run, m_have, m_sx, m_sxf;
    bit [3:0] m_hi;
    bit [4:0] m_ch;
    bit [6:0] m_d0;
    bit [7:0] m_err;
    // expected event
    bit        e_v, e_sxs, e_sxe;
    bit [2:0]  e_k;
    bit [4:0]  e_ch;
    bit [6:0]  e_d1, e_d2;
    bit [15:0] e_bend;
    string     tag;

    function automatic bit [2:0] kind_code(input bit [3:0] hi);
        case (hi)
            4'h8, 4'h9: return 3'd1;
            4'hB: return 3'd2;
            4'hC: return 3'd3;
            4'hD: return 3'd4;
            4'hE: return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_run = 0; m_have = 0; m_sx = 0; m_sxf = 0; m_hi = 0; m_ch = 0; m_d0 = 0; m_err = 0;
    endtask

    task automatic emit_chan(input bit [6:0] a, input bit [6:0] b);
        bit [2:0] k = kind_code(m_hi);
        if (k == 3'd0) begin tag = "R1"; return; end
        if (m_ch >= 26) begin tag = "R4"; return; end
        e_v = 1; e_k = k; e_ch = m_ch; e_d1 = a;
        e_d2 = (m_hi == 4'h8) ? 7'h00 : b;
        tag = (k == 3'd1) ? "R3" : (k == 3'd5) ? "R5" : "R1";
        if (k == 3'd5) e_bend = 16'h8000 | ({9'd0, b} << 7) | {9'd0, a};
    endtask

    task automatic model_step(input bit [7:0] b, input bit p);
        e_v = 0; e_k = 0; e_ch = 0; e_d1 = 0; e_d2 = 0; e_bend = 0; e_sxs = 0; e_sxe = 0;
        tag = "R7";
        if (b == 8'hF0) begin
            m_sx = 1; m_sxf = 1; m_run = 0; m_have = 0; tag = "R6";
        end else if (b == 8'hF7) begin
            tag = "R8";
            if (m_sx) begin
                e_v = 1; e_k = 3'd6; e_sxs = m_sxf; e_sxe = 1; m_sx = 0; m_sxf = 0; tag = "R6";
            end
        end else if (b[7] && b[7:4] != 4'hF) begin
            m_run = 1; m_hi = b[7:4]; m_ch = {p, b[3:0]}; m_have = 0; m_sx = 0; m_sxf = 0;
            tag = "R2";
        end else if (b[7]) begin
            m_run = 0; m_have = 0; m_sx = 0; m_sxf = 0;
        end else if (m_sx) begin
            e_v = 1; e_k = 3'd6; e_d1 = b[6:0]; e_sxs = m_sxf; m_sxf = 0; tag = "R6";
        end else if (!m_run) begin
            if (m_err != 8'hFF) m_err++;
            tag = "R10";
        end else if (m_hi == 4'hC || m_hi == 4'hD) begin
            emit_chan(b[6:0], 7'h00);
        end else if (m_have) begin
            m_have = 0;
            emit_chan(m_d0, b[6:0]);
        end else begin
            m_d0 = b[6:0]; m_have = 1; tag = "R9";
        end
    endtask

    task automatic push(input bit [7:0] b, input bit p, input bit v);
        @(negedge clk);
        in_valid = v; in_byte = b; in_port = p;
        if (v) model_step(b, p);
        else begin
            e_v = 0; tag = "R12";
        end
        @(posedge clk); #1;
        n_checks++;
        if (ev_valid !== e_v ||
            (e_v && {ev_kind, ev_chan, ev_d1, ev_d2, ev_bend, ev_sx_start, ev_sx_end} !==
                    {e_k, e_ch, e_d1, e_d2, e_bend, e_sxs, e_sxe})) begin
            n_errors++;
            $display("FAIL %s byte %h: got v=%b k=%0d ch=%0d d1=%h d2=%h bend=%h s=%b e=%b exp v=%b k=%0d ch=%0d d1=%h d2=%h bend=%h s=%b e=%b",
                     tag, b, ev_valid, ev_kind, ev_chan, ev_d1, ev_d2, ev_bend, ev_sx_start, ev_sx_end,
                     e_v, e_k, e_ch, e_d1, e_d2, e_bend, e_sxs, e_sxe);
        end
        n_checks++;
        if (err_count !== m_err) begin
            n_errors++;
            $display("FAIL R10 err_count got %0d exp %0d", err_count, m_err);
        end
    endtask

    task automatic msg(input bit [7:0] a, input bit [7:0] b, input bit [7:0] c, input bit p);
        push(a, p, 1); push(b, p, 1); push(c, p, 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        n_checks++;
        if (ev_valid !== 1'b0 || err_count !== 8'd0 || in_ready !== 1'b1) begin
            n_errors++;
            $display("FAIL R11 reset v=%b err=%0d rdy=%b exp 0 0 1", ev_valid, err_count, in_ready);
        end

        // R10: orphan data after reset
        push(8'h12, 0, 1);
        // R1 R3 note on, R9 running status with zero velocity
        msg(8'h90, 8'h3C, 8'h40, 0);
        push(8'h3C, 0, 1); push(8'h00, 0, 1);
        // R3 note-off forces zero velocity
        msg(8'h85, 8'h40, 8'h7F, 0);
        msg(8'hB2, 8'h07, 8'h64, 0);
        push(8'hC3, 0, 1); push(8'h05, 0, 1); push(8'h06, 0, 1);
        push(8'hD4, 0, 1); push(8'h33, 0, 1);
        // R5 bend centre and top
        msg(8'hE1, 8'h00, 8'h40, 0);
        push(8'h7F, 0, 1); push(8'h7F, 0, 1);
        // R4 rejected channel 27 under running status, then R2 channel 25
        msg(8'hBB, 8'h07, 8'h10, 1);
        push(8'h08, 1, 1); push(8'h11, 1, 1);
        msg(8'h99, 8'h3C, 8'h40, 1);
        // R8 F7 mid-message ignored
        push(8'h90, 0, 1); push(8'h3C, 0, 1); push(8'hF7, 0, 1); push(8'h40, 0, 1);
        // R7 new status discards partial
        push(8'h90, 0, 1); push(8'h3C, 0, 1); msg(8'h92, 8'h3D, 8'h50, 0);
        // R6 frames
        push(8'hF0, 0, 1); push(8'h01, 0, 1); push(8'h02, 0, 1); push(8'hF7, 0, 1);
        push(8'hF0, 0, 1); push(8'hF7, 0, 1);
        push(8'hF7, 0, 1);
        push(8'hF0, 0, 1); push(8'h05, 0, 1); msg(8'h90, 8'h3C, 8'h40, 0);
        // R10 after other system status
        push(8'hF8, 0, 1); push(8'h05, 0, 1);
        // R12 idle cycle mid-message
        push(8'h91, 0, 1); push(8'h3C, 0, 1); push(8'h55, 0, 0); push(8'h40, 0, 1);
        // R1 nibble A collected silently
        msg(8'hA0, 8'h3C, 8'h40, 0);

        // random mixed stream
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 100;
            bit [7:0] b;
            bit [7:0] sys_pick [6] = '{8'hF1, 8'hF2, 8'hF6, 8'hF8, 8'hFA, 8'hFE};
            if (r < 50)      b = {1'b0, 7'($urandom)};
            else if (r < 80) b = {1'b1, 3'(($urandom % 7)), 4'($urandom)};
            else if (r < 86) b = 8'hF0;
            else if (r < 92) b = 8'hF7;
            else             b = sys_pick[$urandom % 6];
            if (b[7:4] == 4'hF && b != 8'hF0 && b != 8'hF7 && (r < 92)) b = 8'hF8;
            push(b, 1'($urandom), ($urandom % 8) != 0);
        end

        // R10 saturation
        push(8'hFE, 0, 1);
        for (int i = 0; i < 270; i++) push(8'h01, 0, 1);
        n_checks++;
        if (err_count !== 8'hFF) begin
            n_errors++;
            $display("FAIL R10 saturation got %0d exp 255", err_count);
        end

        @(negedge clk); in_valid = 1'b0;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(1_500_000);
        if (!done) begin
            done = 1;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule